// File: doc/BRIEF.md
# Double-Buffered LED Channel Register Bank

This block is the register file that sits between a byte-wide serial slave and the PWM engine of a twelve-channel LED driver. The slave hands it one address/data write per cycle through a strobe, and reads any register back through a registered read-data port. The bank keeps a run (shutdown) bit, a global enable bit and a PWM rate-select bit. It also keeps two sets of per-channel registers: an 8-bit duty value and a 6-bit current-level code.

The per-channel registers are double-buffered. A slave write lands only in a shadow copy, which the read port returns. The shadow copies reach the active outputs that feed the PWM block only when a commit command is written. A commit copies every duty and level shadow into the active set on the same clock edge, so all twelve channels change brightness together. A separate reset command clears the whole bank: shadows, active copies and control bits. The control bits have no shadow and act at once.

Top module: `led_regbank`

## Requirements
- R1: After the synchronous reset input, every output is zero: run bit, global enable, rate select, all active duty and level values, and the read data. Every register then reads back as 00h.
- R2: A write to address 04h+i (i = 0..11) stores the 8-bit data in the duty shadow of channel i, which reads back at that address. The active duty outputs do not change.
- R3: A write to address 17h+i (i = 0..11) stores data bits 5:0 in the level shadow of channel i, and the active level outputs do not change. Reads of that address return the shadow in bits 5:0, with bits 7:6 zero.
- R4: Writing 00h to address 13h copies all twelve duty shadows and all twelve level shadows into the active outputs on the same clock edge. The new values are visible once that write has been clocked.
- R5: Writing any non-zero value to address 13h or to address 2Fh changes no register and no output.
- R6: Writing 00h to address 2Fh clears every register (shadows, active copies and the three control bits) on that clock edge.
- R7: Address 00h holds the run bit, 26h the global enable and 27h the rate select (1 = slow rate), each in data bit 0. Other written bits are dropped, and upper read bits are zero.
- R8: Reads of address 13h, of 2Fh and of any unmapped address return 00h. Writes to unmapped addresses change no register and no output.
- R9: Read data is registered: it shows the register selected by the address one clock edge earlier. A read in the same cycle as a write to that address returns the value held before the write.
- R10: Writes to the three control bits drive their outputs from the next clock edge, with no commit needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current address and data |
| addr | input | 8 | Register address for writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for the previous cycle's address |
| run_o | output | 1 | Run bit (0 = software shutdown) |
| gen_o | output | 1 | Global channel enable |
| fsel_o | output | 1 | PWM rate select (1 = slow rate) |
| duty_o | output | NUM_CH*DUTY_W | Active duty values, channel i in bits i*DUTY_W upward |
| level_o | output | NUM_CH*LEVEL_W | Active level codes, channel i in bits i*LEVEL_W upward |

## Verification
Two functions can fall in the same cycle: a read of a register and a write to that same register, because the single port carries a read address while the strobe is high. The bench drives a write and samples the read data after that edge. It expects the value from its model before the update, then reads again and expects the new value. Commit and reset commands also arrive between shadow writes in the random stream. After every write, the bench compares the active outputs with a model that updates the active copies only on a 00h commit.

// File: rtl/led_regbank_pkg.sv
package led_regbank_pkg;
  localparam int BUS_W = 8;
  localparam logic [BUS_W-1:0] ADR_RUN   = 8'h00;
  localparam logic [BUS_W-1:0] ADR_DUTY0 = 8'h04;
  localparam logic [BUS_W-1:0] ADR_CMT   = 8'h13;
  localparam logic [BUS_W-1:0] ADR_LVL0  = 8'h17;
  localparam logic [BUS_W-1:0] ADR_GEN   = 8'h26;
  localparam logic [BUS_W-1:0] ADR_FSEL  = 8'h27;
  localparam logic [BUS_W-1:0] ADR_CLR   = 8'h2F;
  localparam logic [BUS_W-1:0] CMD_KEY   = 8'h00;

  typedef struct packed {
    logic run;
    logic gen;
    logic fsel;
  } ctrl_bits_t;
endpackage

// File: rtl/led_addr_decode.sv
module led_addr_decode
  import led_regbank_pkg::*;
#(
  parameter int NUM_CH = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [NUM_CH-1:0] duty_we,
  output logic [NUM_CH-1:0] lvl_we,
  output logic              run_we,
  output logic              gen_we,
  output logic              fsel_we,
  output logic              commit,
  output logic              clr
);
  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      assign duty_we[g] = wr_en && (addr == ADR_DUTY0 + BUS_W'(g));
      assign lvl_we[g]  = wr_en && (addr == ADR_LVL0 + BUS_W'(g));
    end
  endgenerate

  assign run_we  = wr_en && (addr == ADR_RUN);
  assign gen_we  = wr_en && (addr == ADR_GEN);
  assign fsel_we = wr_en && (addr == ADR_FSEL);
  assign commit  = wr_en && (addr == ADR_CMT) && (wdata == CMD_KEY);
  assign clr     = wr_en && (addr == ADR_CLR) && (wdata == CMD_KEY);

  // R8
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({duty_we, lvl_we, run_we, gen_we, fsel_we, commit, clr}));
endmodule

// File: rtl/led_shadow_bank.sv
module led_shadow_bank #(
  parameter int NUM_CH = 12,
  parameter int W      = 8,
  localparam int FLAT_W = NUM_CH * W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              commit,
  input  logic [NUM_CH-1:0] we,
  input  logic [W-1:0]      wdata,
  output logic [FLAT_W-1:0] shadow_o,
  output logic [FLAT_W-1:0] active_o
);
  logic [FLAT_W-1:0] shd_q;
  logic [FLAT_W-1:0] act_q;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          shd_q[g*W +: W] <= '0;
        end else if (we[g]) begin
          shd_q[g*W +: W] <= wdata;
        end
      end

      always_ff @(posedge clk) begin
        if (rst || clr) begin
          act_q[g*W +: W] <= '0;
        end else if (commit) begin
          act_q[g*W +: W] <= shd_q[g*W +: W];
        end
      end
    end
  endgenerate

  assign shadow_o = shd_q;
  assign active_o = act_q;

  // R2
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!commit && !clr) |=> $stable(act_q));

  // R4
  commit_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && !clr) |=> (act_q == $past(shd_q)));

  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (shd_q == '0) && (act_q == '0));
endmodule

// File: rtl/led_ctrl_bits.sv
module led_ctrl_bits
  import led_regbank_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       run_we,
  input  logic       gen_we,
  input  logic       fsel_we,
  input  logic       bit_in,
  output ctrl_bits_t ctrl_o
);
  ctrl_bits_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ctrl_q <= '0;
    end else begin
      if (run_we)  ctrl_q.run  <= bit_in;
      if (gen_we)  ctrl_q.gen  <= bit_in;
      if (fsel_we) ctrl_q.fsel <= bit_in;
    end
  end

  assign ctrl_o = ctrl_q;

  // R10
  run_write_chk: assert property (@(posedge clk) disable iff (rst)
    (run_we && !clr) |=> (ctrl_q.run == $past(bit_in)));

  // R7
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_we && !gen_we && !fsel_we && !clr) |=> $stable(ctrl_q));
endmodule

// File: rtl/led_regbank.sv
module led_regbank
  import led_regbank_pkg::*;
#(
  parameter int NUM_CH  = 12,
  parameter int DUTY_W  = 8,
  parameter int LEVEL_W = 6,
  localparam int DUTY_FLAT = NUM_CH * DUTY_W,
  localparam int LVL_FLAT  = NUM_CH * LEVEL_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [7:0]           addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic                 run_o,
  output logic                 gen_o,
  output logic                 fsel_o,
  output logic [DUTY_FLAT-1:0] duty_o,
  output logic [LVL_FLAT-1:0]  level_o
);
  logic [NUM_CH-1:0] duty_we, lvl_we;
  logic run_we, gen_we, fsel_we, commit, clr;
  logic [DUTY_FLAT-1:0] duty_shd;
  logic [LVL_FLAT-1:0]  lvl_shd;
  ctrl_bits_t ctrl;
  logic [BUS_W-1:0] rd_next;
  logic             rd_hit;
  logic [BUS_W-1:0] rdata_q;

  led_addr_decode #(.NUM_CH(NUM_CH)) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .duty_we(duty_we), .lvl_we(lvl_we), .run_we(run_we), .gen_we(gen_we),
    .fsel_we(fsel_we), .commit(commit), .clr(clr)
  );

  led_shadow_bank #(.NUM_CH(NUM_CH), .W(DUTY_W)) u_duty (
    .clk(clk), .rst(rst), .clr(clr), .commit(commit), .we(duty_we),
    .wdata(wdata[DUTY_W-1:0]), .shadow_o(duty_shd), .active_o(duty_o)
  );

  led_shadow_bank #(.NUM_CH(NUM_CH), .W(LEVEL_W)) u_lvl (
    .clk(clk), .rst(rst), .clr(clr), .commit(commit), .we(lvl_we),
    .wdata(wdata[LEVEL_W-1:0]), .shadow_o(lvl_shd), .active_o(level_o)
  );

  led_ctrl_bits u_ctrl (
    .clk(clk), .rst(rst), .clr(clr), .run_we(run_we), .gen_we(gen_we),
    .fsel_we(fsel_we), .bit_in(wdata[0]), .ctrl_o(ctrl)
  );

  // Read mux: shadows for channel registers, zero for write-only and holes.
  always_comb begin
    rd_next = '0;
    rd_hit  = 1'b0;
    if (addr == ADR_RUN)  begin rd_next[0] = ctrl.run;  rd_hit = 1'b1; end
    if (addr == ADR_GEN)  begin rd_next[0] = ctrl.gen;  rd_hit = 1'b1; end
    if (addr == ADR_FSEL) begin rd_next[0] = ctrl.fsel; rd_hit = 1'b1; end
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADR_DUTY0 + BUS_W'(i)) begin
        rd_next[DUTY_W-1:0] = duty_shd[i*DUTY_W +: DUTY_W];
        rd_hit = 1'b1;
      end
      if (addr == ADR_LVL0 + BUS_W'(i)) begin
        rd_next[LEVEL_W-1:0] = lvl_shd[i*LEVEL_W +: LEVEL_W];
        rd_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign rdata  = rdata_q;
  assign run_o  = ctrl.run;
  assign gen_o  = ctrl.gen;
  assign fsel_o = ctrl.fsel;

  // R5
  bad_key_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == ADR_CMT || addr == ADR_CLR) && wdata != CMD_KEY)
      |=> $stable(duty_o) && $stable(level_o) && $stable({run_o, gen_o, fsel_o}));

  // R8
  hole_read_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> (rdata == '0));

  // R3
  level_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (addr >= ADR_LVL0 && addr < ADR_LVL0 + BUS_W'(NUM_CH)) |=> (rdata[7:LEVEL_W] == '0));
endmodule

// File: tb/led_regbank_tb_top.sv
module led_regbank_tb_top;
  localparam int NCH = 12;
  localparam int DW  = 8;
  localparam int LW  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic run_o, gen_o, fsel_o;
  logic [NCH*DW-1:0] duty_o;
  logic [NCH*LW-1:0] level_o;

  led_regbank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .run_o(run_o), .gen_o(gen_o), .fsel_o(fsel_o),
    .duty_o(duty_o), .level_o(level_o)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [DW-1:0] m_sd [NCH];
  logic [DW-1:0] m_ad [NCH];
  logic [LW-1:0] m_sl [NCH];
  logic [LW-1:0] m_al [NCH];
  logic m_run, m_gen, m_fs;

  task automatic model_clear();
    for (int i = 0; i < NCH; i++) begin
      m_sd[i] = '0; m_ad[i] = '0; m_sl[i] = '0; m_al[i] = '0;
    end
    m_run = 0; m_gen = 0; m_fs = 0;
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    logic [7:0] r;
    r = '0;
    if (a == 8'h00) r[0] = m_run;
    if (a == 8'h26) r[0] = m_gen;
    if (a == 8'h27) r[0] = m_fs;
    if (a >= 8'h04 && a <= 8'h0F) r = m_sd[a - 8'h04];
    if (a >= 8'h17 && a <= 8'h22) r[LW-1:0] = m_sl[a - 8'h17];
    return r;
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h00) m_run = d[0];
    if (a == 8'h26) m_gen = d[0];
    if (a == 8'h27) m_fs  = d[0];
    if (a >= 8'h04 && a <= 8'h0F) m_sd[a - 8'h04] = d;
    if (a >= 8'h17 && a <= 8'h22) m_sl[a - 8'h17] = d[LW-1:0];
    if (a == 8'h13 && d == 8'h00)
      for (int i = 0; i < NCH; i++) begin m_ad[i] = m_sd[i]; m_al[i] = m_sl[i]; end
    if (a == 8'h2F && d == 8'h00) model_clear();
  endtask

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req);
    logic [NCH*DW-1:0] ed;
    logic [NCH*LW-1:0] el;
    for (int i = 0; i < NCH; i++) begin
      ed[i*DW +: DW] = m_ad[i];
      el[i*LW +: LW] = m_al[i];
    end
    check({req, " duty"}, 128'(duty_o), 128'(ed));
    check({req, " level"}, 128'(level_o), 128'(el));
    check({req, " ctrl"}, 128'({run_o, gen_o, fsel_o}), 128'({m_run, m_gen, m_fs}));
  endtask

  // Starts and ends at a negedge.
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    model_wr(a, d);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    wr_en = 0; addr = a;
    @(negedge clk);
    check(req, 128'(rdata), 128'(exp_rd(a)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] old, a, d;
    model_clear();
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1: reset state
    chk_outs("R1");
    check("R1 rdata", 128'(rdata), 128'(0));
    rd(8'h04, "R1 duty read");
    rd(8'h17, "R1 level read");
    rd(8'h00, "R1 run read");

    // R2: duty shadow write, no output change
    wr(8'h04, 8'hA5);
    chk_outs("R2");
    rd(8'h04, "R2 shadow read");
    wr(8'h0F, 8'h3C);
    rd(8'h0F, "R2 last channel read");

    // R3: level shadow, upper bits dropped
    wr(8'h17, 8'hFF);
    chk_outs("R3");
    rd(8'h17, "R3 level read");
    wr(8'h22, 8'h13);
    rd(8'h22, "R3 last level read");

    // R5: non-zero commit key
    wr(8'h13, 8'h01);
    chk_outs("R5 commit key");

    // R4: commit copies everything at once
    wr(8'h13, 8'h00);
    chk_outs("R4");

    // R7 / R10: control bits act at once, bit 0 only
    wr(8'h00, 8'hFE);
    chk_outs("R7 run bit0 only");
    wr(8'h00, 8'hFF);
    chk_outs("R10 run");
    rd(8'h00, "R7 run read");
    wr(8'h26, 8'h01);
    wr(8'h27, 8'h03);
    chk_outs("R10 gen fsel");
    rd(8'h27, "R7 fsel read");

    // R8: write-only and holes
    rd(8'h13, "R8 commit read");
    rd(8'h2F, "R8 clear read");
    rd(8'h30, "R8 hole read");
    wr(8'h10, 8'hFF);
    wr(8'h23, 8'hFF);
    chk_outs("R8 hole write");
    rd(8'h10, "R8 hole readback");
    rd(8'h0F, "R8 neighbour");
    rd(8'h17, "R8 neighbour level");

    // R9: read in the same cycle as a write returns old value
    old = exp_rd(8'h05);
    wr_en = 1; addr = 8'h05; wdata = 8'h5A;
    @(negedge clk);
    check("R9 read during write", 128'(rdata), 128'(old));
    model_wr(8'h05, 8'h5A);
    wr_en = 0;
    rd(8'h05, "R9 read after write");

    // R5: non-zero clear key
    wr(8'h2F, 8'h80);
    chk_outs("R5 clear key");
    rd(8'h04, "R5 clear key shadow");

    // R6: clear command
    wr(8'h2F, 8'h00);
    chk_outs("R6");
    rd(8'h04, "R6 duty shadow");
    rd(8'h22, "R6 level shadow");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      a = 8'($urandom_range(0, 63));
      d = 8'($urandom);
      if ((a == 8'h13 || a == 8'h2F) && ($urandom_range(0, 3) != 0)) d = 8'h00;
      if (a == 8'h2F && $urandom_range(0, 3) != 0) a = 8'h13;
      if ($urandom_range(0, 3) == 0) begin
        rd(a, "R9 random read");
      end else begin
        wr(a, d);
        chk_outs((a == 8'h13) ? "R4 random" : (a == 8'h2F) ? "R6 random" : "R2 random");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule